// File: doc/BRIEF.md
# Indirect Error-Record Feature Read Gate

This block answers a read of a 64-bit fault-generation feature value for the error record that a select index chooses. Before returning any data, it checks the requester's privilege level against a set of trap-control bits in a fixed order of precedence. Each accepted request ends in exactly one of four outcomes:

- an undefined-instruction result,
- a trap to level 2,
- a trap to level 3,
- a data return.

When the outcome is a data return, indexing rules decide whether the read yields the record's stored value or zero.

A request is a single-cycle valid/ready handshake that captures all of its inputs. The outcome code, the data and the syndrome class appear as a registered, one-cycle response in the cycle after the request is accepted. Only one request can be in flight at a time. The stored feature values are modelled as a small computed table: record k holds `DATA_SEED | k`. The caller delivers the exception; this block does not.

Top module: `errgate_read_gate`

## Requirements
- R1: `req_ready_o` is 1 whenever no response is being presented. An accepted request (`req_valid_i` and `req_ready_o` both 1 at a clock edge) produces `rsp_valid_o` = 1 for exactly the following cycle. During that cycle `req_ready_o` is 0, so a request held there is not accepted. After reset, `rsp_valid_o` is 0 and `req_ready_o` is 1.
- R2: The outcome is undefined (`rsp_kind_o` = 2'b01) when `feat_impl_i` is 0 or when `lvl_i` is 0.
- R3: At level 1 the checks apply in this order:
  - undefined if `l3_present_i` = 1, `dbg_undef_prio_i` = 1 and `l3_fi_en_i` = 0;
  - otherwise trap to level 2 (2'b10) if `l2_en_i` = 1 and `l2_fi_en_i` = 0;
  - otherwise the fine-grained check of R4;
  - otherwise the level-3 check of R5;
  - otherwise data (2'b00).
- R4: At level 1 a fine-grained trap to level 2 requires all four of:
  - `l2_en_i` = 1;
  - `fg_impl_i` = 1;
  - `l3_present_i` = 0 or `l3_fg_en_i` = 1;
  - `fg_rd_trap_i` = 1.
- R5: When `l3_present_i` = 1 and `l3_fi_en_i` = 0 (and no earlier check hit), the outcome is undefined if `dbg_undef_i` = 1 and a trap to level 3 (2'b11) otherwise.
- R6: At level 2 only the two level-3 checks apply (R3's first check, then R5), and the level-2 controls have no effect. At level 3 with the feature implemented, the outcome is always data.
- R7: `rsp_ec_o` is 6'h18 for both trap outcomes and 0 for the other outcomes.
- R8: `rsp_data_o` is 0 for every outcome other than data.
- R9: A data read returns 0 in any of these cases:
  - `rec_count_i` is 0;
  - `sel_i` >= `rec_count_i`;
  - `sel_i` >= `N_REC`.
- R10: A data read returns 0 when bit `sel_i` of `rec_first_i` is 0, meaning the record is not the first record of its node.
- R11: A data read returns 0 when the 2-bit injection field `rec_inj_i[2*sel_i +: 2]` is 2'b00.
- R12: Otherwise a data read returns `DATA_SEED | sel_i`, where `DATA_SEED` defaults to 64'h7E51_0000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request |
| req_ready_o | output | 1 | Request can be accepted |
| feat_impl_i | input | 1 | Feature implemented |
| fg_impl_i | input | 1 | Fine-grained trapping implemented |
| lvl_i | input | 2 | Current privilege level |
| l2_en_i | input | 1 | Level 2 enabled |
| l3_present_i | input | 1 | Level 3 present |
| l2_fi_en_i | input | 1 | Level-2 fault-injection enable |
| l3_fi_en_i | input | 1 | Level-3 fault-injection enable |
| l3_fg_en_i | input | 1 | Level-3 fine-grained trap enable |
| fg_rd_trap_i | input | 1 | Read-trap bit for this register |
| dbg_undef_prio_i | input | 1 | Secure-debug undefined takes priority |
| dbg_undef_i | input | 1 | Secure-debug undefined in place of level-3 trap |
| rec_count_i | input | SEL_W | Number of error records |
| sel_i | input | SEL_W | Selected record index |
| rec_first_i | input | N_REC | Per record: first record of its node |
| rec_inj_i | input | 2*N_REC | Per record: 2-bit injection field |
| rsp_valid_o | output | 1 | Response present |
| rsp_kind_o | output | 2 | 00 data, 01 undefined, 10 trap L2, 11 trap L3 |
| rsp_data_o | output | DATA_W | Read value |
| rsp_ec_o | output | 6 | Syndrome exception class |

## Verification
The hardest outcome to reach from the ports is the fine-grained trap to level 2. It needs level 1, level 2 enabled, the level-2 fault-injection enable set, fine-grained support, a passing level-3 enable condition and the read-trap bit, and it must also avoid the earlier undefined check. The stimulus sweeps all 4096 combinations of the ten control bits and the two level bits, so every precedence collision is visited. Record indexing is then exercised with random table masks, counts and selects that run past both the count and the table depth. Requests are held high back-to-back, so the ignored request in each response cycle is also covered.

// File: rtl/errgate_pkg.sv
package errgate_pkg;
  typedef enum logic [1:0] {
    RES_DATA  = 2'b00,
    RES_UNDEF = 2'b01,
    RES_TRAP2 = 2'b10,
    RES_TRAP3 = 2'b11
  } res_kind_e;

  localparam logic [5:0] EC_SYSREG = 6'h18;

  typedef struct packed {
    logic       feat;
    logic       fg_impl;
    logic [1:0] lvl;
    logic       l2_en;
    logic       l3_present;
    logic       l2_fi_en;
    logic       l3_fi_en;
    logic       l3_fg_en;
    logic       fg_rd_trap;
    logic       dbg_undef_prio;
    logic       dbg_undef;
  } gate_ctrl_t;
endpackage

// File: rtl/errgate_trap_decide.sv
module errgate_trap_decide
  import errgate_pkg::*;
(
  input  gate_ctrl_t ctrl_i,
  output res_kind_e  kind_o,
  output logic [5:0] ec_o
);
  logic l3_block, fg_hit, below_top;

  assign l3_block  = ctrl_i.l3_present & ~ctrl_i.l3_fi_en;
  assign fg_hit    = ctrl_i.l2_en & ctrl_i.fg_impl &
                     (~ctrl_i.l3_present | ctrl_i.l3_fg_en) & ctrl_i.fg_rd_trap;
  assign below_top = (ctrl_i.lvl != 2'd3);

  always_comb begin
    kind_o = RES_DATA;
    if (!ctrl_i.feat || ctrl_i.lvl == 2'd0) begin
      kind_o = RES_UNDEF;
    end else if (below_top) begin
      if (l3_block && ctrl_i.dbg_undef_prio)
        kind_o = RES_UNDEF;
      else if (ctrl_i.lvl == 2'd1 && ctrl_i.l2_en && !ctrl_i.l2_fi_en)
        kind_o = RES_TRAP2;
      else if (ctrl_i.lvl == 2'd1 && fg_hit)
        kind_o = RES_TRAP2;
      else if (l3_block)
        kind_o = ctrl_i.dbg_undef ? RES_UNDEF : RES_TRAP3;
    end
  end

  assign ec_o = kind_o[1] ? EC_SYSREG : 6'h00;
endmodule

// File: rtl/errgate_rec_lookup.sv
module errgate_rec_lookup #(
  parameter int unsigned          N_REC     = 8,
  parameter int unsigned          SEL_W     = 16,
  parameter int unsigned          DATA_W    = 64,
  parameter logic [DATA_W-1:0]    DATA_SEED = 64'h7E51_0000_0000_0000
) (
  input  logic [SEL_W-1:0]   count_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [N_REC-1:0]   first_i,
  input  logic [2*N_REC-1:0] inj_i,
  output logic [DATA_W-1:0]  data_o
);
  localparam int unsigned IDX_W = (N_REC > 1) ? $clog2(N_REC) : 1;

  logic [DATA_W-1:0] tbl [N_REC];
  logic [1:0]        inj_f [N_REC];

  for (genvar g = 0; g < N_REC; g++) begin : g_rec
    assign tbl[g]   = DATA_SEED | DATA_W'(g);
    assign inj_f[g] = inj_i[2*g +: 2];
  end

  logic [IDX_W-1:0] idx;
  logic             in_range, present, capable;

  assign idx      = sel_i[IDX_W-1:0];
  assign in_range = (count_i != '0) && (sel_i < count_i) &&
                    (sel_i < SEL_W'(N_REC));
  assign present  = in_range && first_i[idx];
  assign capable  = present && (inj_f[idx] != 2'b00);
  assign data_o   = capable ? tbl[idx] : '0;

  always_comb begin
    // R9
    if (count_i == '0) empty_count_chk: assert (data_o == '0);
  end
endmodule

// File: rtl/errgate_read_gate.sv
module errgate_read_gate
  import errgate_pkg::*;
#(
  parameter int unsigned       N_REC     = 8,
  parameter int unsigned       SEL_W     = 16,
  parameter int unsigned       DATA_W    = 64,
  parameter logic [DATA_W-1:0] DATA_SEED = 64'h7E51_0000_0000_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               feat_impl_i,
  input  logic               fg_impl_i,
  input  logic [1:0]         lvl_i,
  input  logic               l2_en_i,
  input  logic               l3_present_i,
  input  logic               l2_fi_en_i,
  input  logic               l3_fi_en_i,
  input  logic               l3_fg_en_i,
  input  logic               fg_rd_trap_i,
  input  logic               dbg_undef_prio_i,
  input  logic               dbg_undef_i,
  input  logic [SEL_W-1:0]   rec_count_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [N_REC-1:0]   rec_first_i,
  input  logic [2*N_REC-1:0] rec_inj_i,
  output logic               rsp_valid_o,
  output logic [1:0]         rsp_kind_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic [5:0]         rsp_ec_o
);
  gate_ctrl_t        ctrl;
  res_kind_e         dec_kind;
  logic [5:0]        dec_ec;
  logic [DATA_W-1:0] lk_data;
  logic              accept;

  assign ctrl = '{feat: feat_impl_i, fg_impl: fg_impl_i, lvl: lvl_i,
                  l2_en: l2_en_i, l3_present: l3_present_i,
                  l2_fi_en: l2_fi_en_i, l3_fi_en: l3_fi_en_i,
                  l3_fg_en: l3_fg_en_i, fg_rd_trap: fg_rd_trap_i,
                  dbg_undef_prio: dbg_undef_prio_i, dbg_undef: dbg_undef_i};

  errgate_trap_decide u_decide (
    .ctrl_i (ctrl),
    .kind_o (dec_kind),
    .ec_o   (dec_ec)
  );

  errgate_rec_lookup #(
    .N_REC(N_REC), .SEL_W(SEL_W), .DATA_W(DATA_W), .DATA_SEED(DATA_SEED)
  ) u_lookup (
    .count_i (rec_count_i),
    .sel_i   (sel_i),
    .first_i (rec_first_i),
    .inj_i   (rec_inj_i),
    .data_o  (lk_data)
  );

  assign req_ready_o = ~rsp_valid_o;
  assign accept      = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_kind_o  <= RES_DATA;
      rsp_data_o  <= '0;
      rsp_ec_o    <= '0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_kind_o <= dec_kind;
        rsp_data_o <= (dec_kind == RES_DATA) ? lk_data : '0;
        rsp_ec_o   <= dec_ec;
      end
    end
  end

  // R1
  rsp_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o));
  // R1
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R8
  data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o != RES_DATA) |-> rsp_data_o == '0);
  // R7
  ec_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ((rsp_ec_o == 6'h18) == rsp_kind_o[1]));
  // R2
  lvl0_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && lvl_i == 2'd0) |=> rsp_kind_o == RES_UNDEF);
  // R6
  lvl3_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && feat_impl_i && lvl_i == 2'd3)
      |=> rsp_kind_o == RES_DATA);
endmodule

// File: tb/errgate_read_gate_bench.sv
module errgate_read_gate_bench;
  localparam int NREC = 8;
  localparam logic [63:0] SEED = 64'h7E51_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, feat = 0, fg_impl = 0, l2_en = 0, l3_p = 0;
  logic        l2_fi = 0, l3_fi = 0, l3_fg = 0, rd_trap = 0, prio = 0, dbg = 0;
  logic [1:0]  lvl = 0;
  logic [15:0] count = 0, sel = 0;
  logic [NREC-1:0]   first = 0;
  logic [2*NREC-1:0] inj = 0;
  logic        ready, rvalid;
  logic [1:0]  kind;
  logic [63:0] data;
  logic [5:0]  ec;

  errgate_read_gate u_errgate_read_gate (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .feat_impl_i(feat), .fg_impl_i(fg_impl), .lvl_i(lvl), .l2_en_i(l2_en),
    .l3_present_i(l3_p), .l2_fi_en_i(l2_fi), .l3_fi_en_i(l3_fi),
    .l3_fg_en_i(l3_fg), .fg_rd_trap_i(rd_trap), .dbg_undef_prio_i(prio),
    .dbg_undef_i(dbg), .rec_count_i(count), .sel_i(sel), .rec_first_i(first),
    .rec_inj_i(inj), .rsp_valid_o(rvalid), .rsp_kind_o(kind),
    .rsp_data_o(data), .rsp_ec_o(ec));

  int n_cmp = 0, n_bad = 0;
  bit exp_valid = 0;
  int exp_kind = 0;
  logic [63:0] exp_data = 0;
  string ktag = "", dtag = "";

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic void predict(output int k, output string kt,
                                  output logic [63:0] d, output string dt);
    bit blk = l3_p && !l3_fi;
    int s = int'(sel);
    int c = int'(count);
    k = 0; kt = "R6";
    if (!feat) begin k = 1; kt = "R2"; end
    else case (lvl)
      2'd0: begin k = 1; kt = "R2"; end
      2'd1: begin
        kt = "R3";
        if (blk && prio) k = 1;
        else if (l2_en && !l2_fi) k = 2;
        else if (l2_en && fg_impl && (!l3_p || l3_fg) && rd_trap) begin k = 2; kt = "R4"; end
        else if (blk) begin k = dbg ? 1 : 3; kt = "R5"; end
      end
      2'd2: if (blk) k = (prio || dbg) ? 1 : 3;
      default: k = 0;
    endcase
    if (k != 0) begin d = 0; dt = "R8"; end
    else if (c == 0 || s >= c || s >= NREC) begin d = 0; dt = "R9"; end
    else if (!first[s]) begin d = 0; dt = "R10"; end
    else if (inj[2*s +: 2] == 2'b00) begin d = 0; dt = "R11"; end
    else begin d = SEED | 64'(s); dt = "R12"; end
  endfunction

  // inputs are set at a negedge; model the edge, then compare at the next negedge
  task automatic go();
    bit acc = req_valid && !exp_valid;
    int k; logic [63:0] d; string kt, dt;
    if (acc) begin
      predict(k, kt, d, dt);
      exp_kind = k; exp_data = d; ktag = kt; dtag = dt;
    end
    exp_valid = acc;
    @(negedge clk);
    chk("R1 valid", 64'(rvalid), 64'(exp_valid));
    chk("R1 ready", 64'(ready), 64'(!exp_valid));
    if (exp_valid) begin
      chk({ktag, " kind"}, 64'(kind), 64'(exp_kind));
      chk("R7 ec", 64'(ec), (exp_kind >= 2) ? 64'h18 : 64'h0);
      chk({dtag, " data"}, data, exp_data);
    end
  endtask

  task automatic set_ctrl(int b);
    feat = b[0]; fg_impl = b[1]; l2_en = b[2]; l3_p = b[3]; l2_fi = b[4];
    l3_fi = b[5]; l3_fg = b[6]; rd_trap = b[7]; prio = b[8]; dbg = b[9];
    lvl = b[11:10];
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(rvalid), 64'h0);
    chk("R1 reset ready", 64'(ready), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    // exhaustive control sweep, records all readable
    count = 16'd8; first = '1; inj = {NREC{2'b01}};
    for (int b = 0; b < 4096; b++) begin
      set_ctrl(b);
      sel = 16'(b % NREC);
      req_valid = 1'b1; go();
      req_valid = 1'b0; go();
    end
    // record indexing, back-to-back requests at level 3
    set_ctrl(32'hC01);
    req_valid = 1'b1;
    for (int t = 0; t < 1200; t++) begin
      if (!exp_valid) begin
        count = 16'($urandom_range(0, 10));
        sel   = 16'($urandom_range(0, 11));
        first = NREC'($urandom);
        inj   = (2*NREC)'($urandom);
      end
      go();
    end
    // boundary selects
    first = '1; inj = '1;
    for (int s = 0; s < 12; s++) begin
      count = (s % 2) ? 16'hFFFF : 16'(s);
      sel = 16'(s);
      req_valid = 1'b1; go();
      req_valid = 1'b0; go();
    end
    // fully random traffic
    for (int t = 0; t < 2000; t++) begin
      req_valid = 1'($urandom);
      set_ctrl(int'($urandom_range(0, 4095)));
      count = 16'($urandom_range(0, 10));
      sel   = 16'($urandom_range(0, 11));
      first = NREC'($urandom);
      inj   = (2*NREC)'($urandom);
      go();
    end
    req_valid = 1'b0;
    go();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule